// File: doc/BRIEF.md
# Two-Operand ALU with Condition Flags

This block is the arithmetic and logic datapath of a small 16-bit processor whose instructions name a destination operand and a source operand. Each cycle it takes the destination value, the source value, the current carry flag and a 4-bit operation code. It returns a result meant to overwrite the destination, a strobe that says whether that write should happen, and four condition flags: carry, zero, signed overflow and negative.

The result, the write strobe and the next-flag vector are purely combinational. A flag register inside the block loads the next-flag vector on a rising clock edge when the flag-update enable is high and the operation code is one the block knows. The register output is fed back by the surrounding core as the carry input of the next instruction, so that multi-word add and subtract chains work. Operand fetch, addressing and register-file writeback belong to the core around this block.

Top module: `alu16_flagunit`

## Requirements
- R1: Code 0 (add) gives A+B and code 2 (add with carry) gives A+B+carry_i, both modulo 2^16. C is the carry out of bit 15, and V is set when the two operands share a sign and the result sign differs from it.
- R2: Code 1 (subtract) gives A-B and code 3 (subtract with borrow) gives A-B-carry_i, both modulo 2^16. C is set when the unsigned subtraction borrows, and V is set when the operands differ in sign and the result sign differs from A.
- R3: Code 4 gives A AND B, code 5 gives A OR B, code 6 gives A XOR B and code 7 gives the bitwise inverse of A. All four clear C and V.
- R4: Code 8 shifts A left by one bit with a zero entering bit 0, and C takes the old bit 15. Code 9 shifts A right by one bit with a zero entering bit 15, and C takes the old bit 0. V is cleared for both.
- R5: Code 10 rotates A left by one bit, so the old bit 15 lands in bit 0 and is also copied into C. Code 11 rotates A right by one bit, so the old bit 0 lands in bit 15 and is also copied into C. V is cleared for both.
- R6: Z is set exactly when the 16-bit value the flags describe is zero, and N equals bit 15 of that value.
- R7: Code 12 (compare) produces the flags of A-B, holds result_we_o low and presents A unchanged on result_o.
- R8: Codes 13 to 15 present A unchanged on result_o, hold result_we_o low and leave flags_q_o unchanged even when flag_en_i is high.
- R9: flags_q_o is packed as {C,Z,V,N} with C in bit 3 and N in bit 0. An asynchronous active-low reset clears it to 0. On a rising edge it loads flags_next_o when flag_en_i is high and the code is in the range 0 to 12, and it holds its value otherwise.
- R10: result_we_o is high for codes 0 to 11 and low for all other codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| dst_a_i | input | 16 | Destination operand A |
| src_b_i | input | 16 | Source operand B |
| carry_i | input | 1 | Incoming carry flag |
| flag_en_i | input | 1 | Allows the flag register to load |
| result_o | output | 16 | Value for the destination |
| result_we_o | output | 1 | Destination write strobe |
| flags_next_o | output | 4 | Combinational {C,Z,V,N} for this operation |
| flags_q_o | output | 4 | Registered {C,Z,V,N} |

## Verification
In a single cycle the block can consume the carry flag as an operand and overwrite that same flag with the carry out of the same operation. The bench provokes this by chaining 32-bit additions and subtractions, where the low word runs with flag update enabled and the high word runs with carry_i taken from flags_q_o on the following cycle. It judges the pair of 16-bit results against a 32-bit sum or difference computed in the bench. Separate steps pair flag_en_i with compare and with unused codes, to show that a flag load can happen with no result write, or be suppressed altogether.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int DATA_W  = 16;
  localparam int OP_W    = 4;
  localparam int FLAG_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_ADC = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_NOT = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9,
    OP_ROL = 4'd10,
    OP_ROR = 4'd11,
    OP_CMP = 4'd12,
    OP_RSV13 = 4'd13,
    OP_RSV14 = 4'd14,
    OP_RSV15 = 4'd15
  } alu_op_e;

  localparam logic [OP_W-1:0] LAST_VALID_OP = OP_CMP;
  localparam logic [OP_W-1:0] LAST_WRITE_OP = OP_ROR;

  // Flag word: c in the top bit, n in the bottom bit.
  typedef struct packed {
    logic c;
    logic z;
    logic v;
    logic n;
  } flags_t;

  // Extended add or subtract; the extra top bit is carry (add) or borrow (sub).
  function automatic logic [DATA_W:0] ext_addsub(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic              cin,
    input logic              sub
  );
    logic [DATA_W:0] ea;
    logic [DATA_W:0] eb;
    logic [DATA_W:0] ec;
    ea = {1'b0, a};
    eb = {1'b0, b};
    ec = {{DATA_W{1'b0}}, cin};
    if (sub) return ea - eb - ec;
    else     return ea + eb + ec;
  endfunction

  // Signed overflow from the three sign bits.
  function automatic logic signed_ovf(
    input logic a_msb,
    input logic b_msb,
    input logic r_msb,
    input logic sub
  );
    logic same_in;
    same_in = sub ? (a_msb != b_msb) : (a_msb == b_msb);
    return same_in && (r_msb != a_msb);
  endfunction

  function automatic logic is_zero(input logic [DATA_W-1:0] v);
    return (v == '0);
  endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  alu_op_e          op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic             cin_i,
  output logic [DW-1:0]    res_o,
  output logic             c_o,
  output logic             v_o
);

  logic          do_sub;
  logic          use_cin;
  logic          cin_eff;
  logic [DW:0]   wide;

  always_comb begin
    do_sub  = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CMP);
    use_cin = (op_i == OP_ADC) || (op_i == OP_SBC);
  end

  assign cin_eff = use_cin & cin_i;
  assign wide    = ext_addsub(a_i, b_i, cin_eff, do_sub);
  assign res_o   = wide[DW-1:0];
  assign c_o     = wide[DW];
  assign v_o     = signed_ovf(a_i[DW-1], b_i[DW-1], wide[DW-1], do_sub);

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  alu_op_e          op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  output logic [DW-1:0]    res_o
);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      default: res_o = a_i;
    endcase
  end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  alu_op_e          op_i,
  input  logic [DW-1:0]    a_i,
  output logic [DW-1:0]    res_o,
  output logic             c_o
);

  logic          go_left;
  logic          wrap;
  logic          fill_lo;
  logic          fill_hi;
  logic [DW-1:0] left_w;
  logic [DW-1:0] right_w;

  assign go_left = (op_i == OP_SHL) || (op_i == OP_ROL);
  assign wrap    = (op_i == OP_ROL) || (op_i == OP_ROR);
  assign fill_lo = wrap & a_i[DW-1];
  assign fill_hi = wrap & a_i[0];

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign left_w[i] = fill_lo;
    end else begin : g_lo_mid
      assign left_w[i] = a_i[i-1];
    end
    if (i == DW-1) begin : g_hi
      assign right_w[i] = fill_hi;
    end else begin : g_hi_mid
      assign right_w[i] = a_i[i+1];
    end
  end

  assign res_o = go_left ? left_w : right_w;
  assign c_o   = go_left ? a_i[DW-1] : a_i[0];

endmodule

// File: rtl/alu16_flagunit.sv
module alu16_flagunit
  import alu16_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OP_W-1:0]     op_i,
  input  logic [DW-1:0]       dst_a_i,
  input  logic [DW-1:0]       src_b_i,
  input  logic                carry_i,
  input  logic                flag_en_i,
  output logic [DW-1:0]       result_o,
  output logic                result_we_o,
  output logic [FLAG_W-1:0]   flags_next_o,
  output logic [FLAG_W-1:0]   flags_q_o
);

  alu_op_e       op;
  assign op = alu_op_e'(op_i);

  // Operation classes, brought out for the checks below.
  logic cls_arith;
  logic cls_logic;
  logic cls_shift;
  logic op_valid;
  logic op_writes;
  logic flag_load;

  always_comb begin
    cls_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADC) ||
                (op == OP_SBC) || (op == OP_CMP);
    cls_logic = (op == OP_AND) || (op == OP_OR)  || (op == OP_XOR) ||
                (op == OP_NOT);
    cls_shift = (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROL) ||
                (op == OP_ROR);
  end

  assign op_valid  = (op_i <= LAST_VALID_OP);
  assign op_writes = (op_i <= LAST_WRITE_OP);
  assign flag_load = flag_en_i & op_valid;

  logic [DW-1:0] ar_res;
  logic          ar_c;
  logic          ar_v;
  logic [DW-1:0] lg_res;
  logic [DW-1:0] sh_res;
  logic          sh_c;

  alu16_arith #(.DW(DW)) u_arith (
    .op_i  (op),
    .a_i   (dst_a_i),
    .b_i   (src_b_i),
    .cin_i (carry_i),
    .res_o (ar_res),
    .c_o   (ar_c),
    .v_o   (ar_v)
  );

  alu16_logic #(.DW(DW)) u_logic (
    .op_i  (op),
    .a_i   (dst_a_i),
    .b_i   (src_b_i),
    .res_o (lg_res)
  );

  alu16_shift #(.DW(DW)) u_shift (
    .op_i  (op),
    .a_i   (dst_a_i),
    .res_o (sh_res),
    .c_o   (sh_c)
  );

  // Value the flags describe: for compare it is the difference.
  logic [DW-1:0] flag_src;
  flags_t        nxt;

  always_comb begin
    flag_src = dst_a_i;
    nxt      = '0;
    if (cls_arith) begin
      flag_src = ar_res;
      nxt.c    = ar_c;
      nxt.v    = ar_v;
    end else if (cls_logic) begin
      flag_src = lg_res;
    end else if (cls_shift) begin
      flag_src = sh_res;
      nxt.c    = sh_c;
    end
    nxt.z = is_zero(flag_src);
    nxt.n = flag_src[DW-1];
  end

  assign result_o     = op_writes ? flag_src : dst_a_i;
  assign result_we_o  = op_writes;
  assign flags_next_o = nxt;

  flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= '0;
    else if (flag_load) flags_q <= nxt;
  end

  assign flags_q_o = flags_q;

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en_i |=> $stable(flags_q_o));

  // R9
  flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en_i && op_valid) |=> (flags_q_o == $past(flags_next_o)));

  // R8
  unused_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (result_o == dst_a_i) && !result_we_o);

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_writes) |-> (flags_next_o[2] == (result_o == '0)) &&
                    (flags_next_o[0] == result_o[DW-1]));

  // R3
  logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cls_logic |-> !flags_next_o[3] && !flags_next_o[1]);

  // R7
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP) |-> !result_we_o && (result_o == dst_a_i));

  // R4
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHL) |-> !result_o[0] && (flags_next_o[3] == dst_a_i[DW-1]));

  // R5
  rot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROL || op == OP_ROR) |-> ($countones(result_o) == $countones(dst_a_i)));

endmodule

// File: tb/tb_alu16_flagunit.sv
`timescale 1ns/1ps
module tb_alu16_flagunit;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [15:0] dst_a_i;
  logic [15:0] src_b_i;
  logic        carry_i;
  logic        flag_en_i;
  logic [15:0] result_o;
  logic        result_we_o;
  logic [3:0]  flags_next_o;
  logic [3:0]  flags_q_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [3:0] exp_q;
  bit finished = 0;

  alu16_flagunit dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .dst_a_i      (dst_a_i),
    .src_b_i      (src_b_i),
    .carry_i      (carry_i),
    .flag_en_i    (flag_en_i),
    .result_o     (result_o),
    .result_we_o  (result_we_o),
    .flags_next_o (flags_next_o),
    .flags_q_o    (flags_q_o)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent reference: signed and unsigned integer arithmetic.
  task automatic model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic cin, output logic [15:0] r, output logic we,
                       output logic [3:0] fl, output logic vld);
    int ua, ub, uc, sa, sb, t, st;
    logic c, v;
    logic [15:0] fv;
    ua = int'(a); ub = int'(b); uc = cin ? 1 : 0;
    sa = int'($signed(a)); sb = int'($signed(b));
    c = 0; v = 0; r = a; fv = a; we = 0; vld = 1;
    case (op)
      4'd0, 4'd2: begin
        if (op == 4'd0) uc = 0;
        t = ua + ub + uc; st = sa + sb + uc;
        fv = t[15:0]; c = (t > 65535); v = (st > 32767) || (st < -32768);
      end
      4'd1, 4'd3, 4'd12: begin
        if (op != 4'd3) uc = 0;
        t = ua - ub - uc; st = sa - sb - uc;
        fv = t[15:0]; c = (t < 0); v = (st > 32767) || (st < -32768);
      end
      4'd4: fv = a & b;
      4'd5: fv = a | b;
      4'd6: fv = a ^ b;
      4'd7: fv = ~a;
      4'd8: begin fv = (ua * 2) % 65536; c = a[15]; end
      4'd9: begin fv = ua / 2; c = a[0]; end
      4'd10: begin fv = ((ua * 2) % 65536) + (a[15] ? 1 : 0); c = a[15]; end
      4'd11: begin fv = (ua / 2) + (a[0] ? 32768 : 0); c = a[0]; end
      default: vld = 0;
    endcase
    if (op <= 4'd11) begin r = fv; we = 1; end
    fl = {c, (fv == 16'h0), v, fv[15]};
  endtask

  // Drive one operation, check the combinational outputs, then the register.
  task automatic step(input string req, input logic [3:0] op, input logic [15:0] a,
                      input logic [15:0] b, input logic cin, input logic fen);
    logic [15:0] r; logic we; logic [3:0] fl; logic vld;
    @(negedge clk);
    op_i = op; dst_a_i = a; src_b_i = b; carry_i = cin; flag_en_i = fen;
    #1;
    model(op, a, b, cin, r, we, fl, vld);
    check(req, "result", {16'h0, result_o}, {16'h0, r});
    check(req, "write strobe", {31'h0, result_we_o}, {31'h0, we});
    if (vld) check(req, "next flags", {28'h0, flags_next_o}, {28'h0, fl});
    if (fen && vld) exp_q = fl;
    @(posedge clk); #1;
    check(fen && vld ? req : "R9", "flag register", {28'h0, flags_q_o}, {28'h0, exp_q});
  endtask

  task automatic t_reset();
    rst_n = 0; op_i = 0; dst_a_i = 0; src_b_i = 0; carry_i = 0; flag_en_i = 0;
    exp_q = 0;
    repeat (3) @(posedge clk);
    #1 check("R9", "reset flags", {28'h0, flags_q_o}, 32'h0);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic t_arith();
    logic [15:0] corners [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};
    foreach (corners[i]) foreach (corners[j]) for (int c = 0; c < 2; c++) begin
      step("R1", 4'd0, corners[i], corners[j], c[0], 1);
      step("R1", 4'd2, corners[i], corners[j], c[0], 1);
      step("R2", 4'd1, corners[i], corners[j], c[0], 1);
      step("R2", 4'd3, corners[i], corners[j], c[0], 1);
    end
    step("R6", 4'd0, 16'hFFFF, 16'h0001, 0, 1);   // zero with carry
    step("R6", 4'd1, 16'h0000, 16'h0001, 0, 1);   // negative with borrow
  endtask

  task automatic t_logic();
    step("R3", 4'd4, 16'hF0F0, 16'h0FF0, 1, 1);
    step("R3", 4'd5, 16'h8000, 16'h0001, 1, 1);
    step("R3", 4'd6, 16'h1234, 16'h1234, 1, 1);
    step("R3", 4'd7, 16'h0000, 16'h5555, 1, 1);
    step("R3", 4'd7, 16'hFFFF, 16'h0000, 0, 1);
  endtask

  task automatic t_shift();
    step("R4", 4'd8, 16'h8001, 16'h0, 1, 1);
    step("R4", 4'd8, 16'h4000, 16'h0, 0, 1);
    step("R4", 4'd9, 16'h8001, 16'h0, 1, 1);
    step("R4", 4'd9, 16'h0001, 16'h0, 0, 1);
    step("R5", 4'd10, 16'h8001, 16'h0, 0, 1);
    step("R5", 4'd10, 16'h7FFF, 16'h0, 1, 1);
    step("R5", 4'd11, 16'h8001, 16'h0, 0, 1);
    step("R5", 4'd11, 16'hFFFE, 16'h0, 1, 1);
  endtask

  task automatic t_cmp_unused();
    step("R7", 4'd12, 16'h0005, 16'h0005, 0, 1);
    step("R7", 4'd12, 16'h0003, 16'h0009, 1, 1);
    step("R7", 4'd12, 16'h8000, 16'h0001, 0, 1);
    step("R10", 4'd12, 16'hABCD, 16'h0001, 0, 0);
    step("R1", 4'd0, 16'h7FFF, 16'h0001, 0, 1);   // set a nonzero flag state
    for (int u = 13; u < 16; u++) step("R8", u[3:0], 16'h1357, 16'h2468, 1, 1);
  endtask

  task automatic t_hold();
    step("R9", 4'd1, 16'h0000, 16'h0001, 0, 1);
    step("R9", 4'd0, 16'h0001, 16'h0001, 0, 0);
    step("R9", 4'd6, 16'hAAAA, 16'hAAAA, 0, 0);
  endtask

  // Carry consumed and rewritten in one cycle across a 32-bit chain.
  task automatic t_chain();
    logic [31:0] x, y, got, want;
    logic [31:0] pairs [4] = '{32'h0000FFFF, 32'h7FFFFFFF, 32'h12348000, 32'hFFFFFFFF};
    foreach (pairs[i]) begin
      x = pairs[i]; y = pairs[(i + 1) % 4];
      step("R1", 4'd0, x[15:0], y[15:0], 0, 1);
      got[15:0] = result_o;
      step("R1", 4'd2, x[31:16], y[31:16], flags_q_o[3], 1);
      got[31:16] = result_o;
      want = x + y;
      check("R1", "32-bit sum", got, want);
      step("R2", 4'd1, x[15:0], y[15:0], 0, 1);
      got[15:0] = result_o;
      step("R2", 4'd3, x[31:16], y[31:16], flags_q_o[3], 1);
      got[31:16] = result_o;
      want = x - y;
      check("R2", "32-bit difference", got, want);
      check("R2", "32-bit borrow", {31'h0, flags_q_o[3]}, {31'h0, x < y});
    end
  endtask

  task automatic t_random();
    logic [31:0] s;
    for (int k = 0; k < 400; k++) begin
      s = $urandom;
      step("R10", 4'(k % 16), s[15:0], s[31:16], s[k % 32], k[2] | k[0]);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    t_reset();
    t_arith();
    t_logic();
    t_shift();
    t_cmp_unused();
    t_hold();
    t_chain();
    t_random();
    t_reset();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule